// File: doc/BRIEF.md
# Shared Four-Channel PS/2 Frame Engine

This block is one PS/2 shift engine that serves four open-drain PS/2 ports. Each port has a clock line and a data line. The block reads both lines through synchronizers and a glitch filter, and it can pull either line low through an active-low pull output. A small register file gives the host control over the block. Through it the host sets the engine's mode, forces any port's clock or data line low, reads the transfer status and the data byte, and unmasks two interrupt sources.

In receive mode the engine watches every port whose clock is released. It locks onto the first port that shows a falling clock edge, then shifts in an 11-bit frame on that port's falling edges. After the frame it reports a parity error and a frame error. In transmit mode the host first holds every clock low, then loads a byte. Next it pulls the chosen port's data line low and releases that port's clock. The engine then takes ownership of that data line and shifts the byte out on the device's clock. It ends by sampling the device's acknowledge.

The host clears the engine by writing the override register to its inhibit pattern: every clock line pulled low and every data line released. That pattern also clears the sticky start and end flags.

Top module: `ps2_shared_engine`

## Requirements
- R1: After reset every status bit reads 0 and `irq` is low. All four clock pulls are active (`ps2_clk_low_o` = 4'hF) and no data pull is active.
- R2: Register 1 is the line override. The clock of ports 0..3 is released by bits 3, 4, 5, 7, and the data line of ports 0..3 is released by bits 0, 1, 2, 6. A 0 in a bit drives that port's pull output high, except while the engine owns the data line in transmit.
- R3: Register 0 bit 0 enables the engine and bit 1 selects transmit. With the engine enabled in receive mode, a frame on an open port is sampled on falling edges. The frame is a start bit, 8 data bits with the least significant bit first, odd parity and a stop bit. After the 11th edge, register 4 holds the byte and status bit 1 (end flag) is set.
- R4: Status bit 0 (start flag) sets on the first accepted falling edge and stays set until the inhibit pattern (8'h47) is written. That write clears the start flag, the end flag, both error flags and the channel field.
- R5: Status bits 6:4 give the locked port as 1, 2, 4 or 5 for ports 0, 1, 2, 3, and read 0 while no transfer has started.
- R6: When several ports show their first falling edge in the same cycle, the lowest-numbered port wins. Once a port is locked, edges on other ports do not change the received byte or the channel field.
- R7: Status bit 2 sets at the end of a receive when the data bits plus the parity bit hold an even number of ones.
- R8: Status bit 3 sets at the end of a receive when the start bit was high or the stop bit was low.
- R9: In transmit mode the engine drives data bit k after falling edge k+1 for k = 0..7. It drives the odd-parity bit after edge 9 and releases the line after edge 10. At edge 11 it sets the end flag, and it also sets status bit 3 if the data line is high (no acknowledge).
- R10: `irq` is high when the start flag is set with register 3 bit 0, or when the end flag is set with register 3 bit 1.
- R11: While register 0 bit 0 is clear, or a port's clock bit in the override is clear, falling edges on that port start no transfer and the status stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the PS/2 clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control, 1 override, 2 status, 3 interrupt enable, 4 data) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| ps2_clk_i | input | 4 | Sensed clock line of each port |
| ps2_dat_i | input | 4 | Sensed data line of each port |
| ps2_clk_low_o | output | 4 | Pull each port's clock line low |
| ps2_dat_low_o | output | 4 | Pull each port's data line low |

## Verification
Start-bit detection on two ports can happen in the same system cycle. Two device models therefore start frames on the same clock tick, so their falling edges reach the arbiter together. The bench expects the lower port's channel code and the lower port's byte, and neither may be mixed with the other frame. A staggered variant starts the higher port first and checks that the later edges on the lower port are ignored.

// File: rtl/ps2_eng_pkg.sv
package ps2_eng_pkg;

   localparam int unsigned PORTS   = 4;
   localparam int unsigned ADDR_W  = 3;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_OVR  = 3'd1;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
   localparam logic [ADDR_W-1:0] A_IEN  = 3'd3;
   localparam logic [ADDR_W-1:0] A_DATA = 3'd4;

   localparam logic [7:0] OVR_INHIBIT = 8'h47;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_SHIFT = 2'd1,
      ENG_DONE  = 2'd2
   } eng_state_t;

   typedef struct packed {
      logic       rsvd;
      logic [2:0] chan;
      logic       frm_err;
      logic       par_err;
      logic       end_f;
      logic       start_f;
   } stat_t;

   function automatic int unsigned clk_bit_pos(int unsigned port);
      case (port)
         0: return 3;
         1: return 4;
         2: return 5;
         default: return 7;
      endcase
   endfunction

   function automatic int unsigned dat_bit_pos(int unsigned port);
      case (port)
         0: return 0;
         1: return 1;
         2: return 2;
         default: return 6;
      endcase
   endfunction

   function automatic logic [2:0] chan_code(logic [1:0] idx);
      case (idx)
         2'd0: return 3'd1;
         2'd1: return 3'd2;
         2'd2: return 3'd4;
         default: return 3'd5;
      endcase
   endfunction

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic fell_o
);

   localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ps2_line_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("ps2_line_filter: FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   samp;
   logic                   level_q;
   logic                   fell_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   assign samp = sync_q[SYNC_STAGES-1];

   if (FILT_LEN == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level_q <= 1'b1;
            fell_q  <= 1'b0;
         end else begin
            level_q <= samp;
            fell_q  <= level_q & ~samp;
         end
      end
   end else begin : g_count
      logic [CW-1:0] agree_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level_q <= 1'b1;
            fell_q  <= 1'b0;
            agree_q <= '0;
         end else begin
            fell_q <= 1'b0;
            if (samp != level_q) begin
               if (agree_q == CW'(FILT_LEN - 1)) begin
                  level_q <= samp;
                  fell_q  <= ~samp;
                  agree_q <= '0;
               end else begin
                  agree_q <= agree_q + 1'b1;
               end
            end else begin
               agree_q <= '0;
            end
         end
      end
   end

   assign level_o = level_q;
   assign fell_o  = fell_q;

endmodule

// File: rtl/ps2_chan_arbiter.sv
module ps2_chan_arbiter #(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] fell_i,
   input  logic [NUM_CH-1:0] allow_i,
   output logic              hit_o,
   output logic [IW-1:0]     idx_o
);

   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (fell_i[i] && allow_i[i]) begin
            hit_o = 1'b1;
            idx_o = IW'(i);
         end
      end
   end

endmodule

// File: rtl/ps2_frame_engine.sv
module ps2_frame_engine
   import ps2_eng_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              xmit_i,
   input  logic [NUM_CH-1:0] ch_en_i,
   input  logic [NUM_CH-1:0] fell_i,
   input  logic [NUM_CH-1:0] dat_i,
   input  logic [7:0]        tx_byte_i,
   output logic              sot_o,
   output logic              eot_o,
   output logic              perr_o,
   output logic              ferr_o,
   output logic [IW-1:0]     ch_idx_o,
   output logic              tx_own_o,
   output logic              tx_low_o,
   output logic [7:0]        rx_byte_o,
   output logic              rx_load_o
);

   localparam logic [3:0] LAST_DATA = 4'd8;
   localparam logic [3:0] PAR_EDGE  = 4'd9;

   eng_state_t    state_q;
   logic [IW-1:0] ch_q;
   logic [3:0]    cnt_q;
   logic [7:0]    sr_q;
   logic [7:0]    tx_sr_q;
   logic          par_q;
   logic          tx_par_q;
   logic          start_bad_q;
   logic          mode_tx_q;
   logic          sot_q, eot_q, perr_q, ferr_q;
   logic          tx_low_q;
   logic          rx_load_q;

   logic          arb_hit;
   logic [IW-1:0] arb_idx;
   logic          cur_fell;
   logic          cur_dat;

   ps2_chan_arbiter #(.NUM_CH(NUM_CH)) u_arb (
      .fell_i  (fell_i),
      .allow_i (ch_en_i),
      .hit_o   (arb_hit),
      .idx_o   (arb_idx)
   );

   assign cur_fell = fell_i[ch_q];
   assign cur_dat  = dat_i[ch_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ENG_IDLE;
         ch_q        <= '0;
         cnt_q       <= '0;
         sr_q        <= '0;
         tx_sr_q     <= '0;
         par_q       <= 1'b0;
         tx_par_q    <= 1'b0;
         start_bad_q <= 1'b0;
         mode_tx_q   <= 1'b0;
         sot_q       <= 1'b0;
         eot_q       <= 1'b0;
         perr_q      <= 1'b0;
         ferr_q      <= 1'b0;
         tx_low_q    <= 1'b0;
         rx_load_q   <= 1'b0;
      end else begin
         rx_load_q <= 1'b0;
         if (!run_i) begin
            state_q  <= ENG_IDLE;
            cnt_q    <= '0;
            sot_q    <= 1'b0;
            eot_q    <= 1'b0;
            perr_q   <= 1'b0;
            ferr_q   <= 1'b0;
            tx_low_q <= 1'b0;
         end else begin
            case (state_q)
               ENG_IDLE: begin
                  if (arb_hit) begin
                     state_q     <= ENG_SHIFT;
                     ch_q        <= arb_idx;
                     cnt_q       <= 4'd1;
                     sot_q       <= 1'b1;
                     par_q       <= 1'b0;
                     mode_tx_q   <= xmit_i;
                     start_bad_q <= ~xmit_i & dat_i[arb_idx];
                     if (xmit_i) begin
                        tx_sr_q  <= tx_byte_i >> 1;
                        tx_low_q <= ~tx_byte_i[0];
                        tx_par_q <= ~^tx_byte_i;
                     end
                  end
               end
               ENG_SHIFT: begin
                  if (cur_fell) begin
                     cnt_q <= cnt_q + 4'd1;
                     if (!mode_tx_q) begin
                        if (cnt_q <= LAST_DATA) begin
                           sr_q  <= {cur_dat, sr_q[7:1]};
                           par_q <= par_q ^ cur_dat;
                        end else if (cnt_q == PAR_EDGE) begin
                           par_q <= par_q ^ cur_dat;
                        end else begin
                           state_q   <= ENG_DONE;
                           eot_q     <= 1'b1;
                           perr_q    <= ~par_q;
                           ferr_q    <= start_bad_q | ~cur_dat;
                           rx_load_q <= 1'b1;
                        end
                     end else begin
                        if (cnt_q < LAST_DATA) begin
                           tx_low_q <= ~tx_sr_q[0];
                           tx_sr_q  <= tx_sr_q >> 1;
                        end else if (cnt_q == LAST_DATA) begin
                           tx_low_q <= ~tx_par_q;
                        end else if (cnt_q == PAR_EDGE) begin
                           tx_low_q <= 1'b0;
                        end else begin
                           state_q <= ENG_DONE;
                           eot_q   <= 1'b1;
                           ferr_q  <= cur_dat;
                        end
                     end
                  end
               end
               default: begin
                  tx_low_q <= 1'b0;
               end
            endcase
         end
      end
   end

   assign sot_o     = sot_q;
   assign eot_o     = eot_q;
   assign perr_o    = perr_q;
   assign ferr_o    = ferr_q;
   assign ch_idx_o  = ch_q;
   assign tx_own_o  = mode_tx_q && (state_q == ENG_SHIFT);
   assign tx_low_o  = tx_low_q;
   assign rx_byte_o = sr_q;
   assign rx_load_o = rx_load_q;

endmodule

// File: rtl/ps2_shared_engine.sv
module ps2_shared_engine
   import ps2_eng_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4,
   parameter int unsigned NUM_CH      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq,
   input  logic [NUM_CH-1:0] ps2_clk_i,
   input  logic [NUM_CH-1:0] ps2_dat_i,
   output logic [NUM_CH-1:0] ps2_clk_low_o,
   output logic [NUM_CH-1:0] ps2_dat_low_o
);

   localparam int unsigned IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH != PORTS) begin : g_bad_ports
      $error("ps2_shared_engine: override layout fixes NUM_CH at 4");
   end

   logic [7:0] ctrl_q, ovr_q, ien_q, data_q;

   logic [NUM_CH-1:0] ch_en, dat_rel;
   logic [NUM_CH-1:0] clk_lvl, clk_fell, dat_lvl, dat_fell_unused;
   logic              mech_rst, run;
   logic              sot, eot, perr, ferr;
   logic [IW-1:0]     ch_idx;
   logic              tx_own, tx_low, rx_load;
   logic [7:0]        rx_byte;
   logic [2:0]        ach;
   stat_t             stat;

   for (genvar p = 0; p < NUM_CH; p++) begin : g_port
      localparam int unsigned CP = clk_bit_pos(p);
      localparam int unsigned DP = dat_bit_pos(p);

      assign ch_en[p]         = ovr_q[CP];
      assign dat_rel[p]       = ovr_q[DP];
      assign ps2_clk_low_o[p] = ~ch_en[p];
      assign ps2_dat_low_o[p] = (tx_own && (ch_idx == IW'(p))) ? tx_low : ~dat_rel[p];

      ps2_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_clk_flt (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_i  (ps2_clk_i[p]),
         .level_o (clk_lvl[p]),
         .fell_o  (clk_fell[p])
      );

      ps2_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_dat_flt (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_i  (ps2_dat_i[p]),
         .level_o (dat_lvl[p]),
         .fell_o  (dat_fell_unused[p])
      );
   end

   assign mech_rst = ~(|ch_en) & (&dat_rel);
   assign run      = ctrl_q[0] & ~mech_rst;

   ps2_frame_engine #(.NUM_CH(NUM_CH)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .xmit_i    (ctrl_q[1]),
      .ch_en_i   (ch_en),
      .fell_i    (clk_fell),
      .dat_i     (dat_lvl),
      .tx_byte_i (data_q),
      .sot_o     (sot),
      .eot_o     (eot),
      .perr_o    (perr),
      .ferr_o    (ferr),
      .ch_idx_o  (ch_idx),
      .tx_own_o  (tx_own),
      .tx_low_o  (tx_low),
      .rx_byte_o (rx_byte),
      .rx_load_o (rx_load)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ovr_q  <= OVR_INHIBIT;
         ien_q  <= '0;
         data_q <= '0;
      end else begin
         if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata;
         if (reg_wr && reg_addr == A_OVR)  ovr_q  <= reg_wdata;
         if (reg_wr && reg_addr == A_IEN)  ien_q  <= reg_wdata;
         if (rx_load)                           data_q <= rx_byte;
         else if (reg_wr && reg_addr == A_DATA) data_q <= reg_wdata;
      end
   end

   assign ach  = sot ? chan_code(2'(ch_idx)) : 3'd0;
   assign stat = '{rsvd: 1'b0, chan: ach, frm_err: ferr, par_err: perr,
                   end_f: eot, start_f: sot};

   always_comb begin
      case (reg_addr)
         A_CTRL:  reg_rdata = ctrl_q;
         A_OVR:   reg_rdata = ovr_q;
         A_STAT:  reg_rdata = stat;
         A_IEN:   reg_rdata = ien_q;
         A_DATA:  reg_rdata = data_q;
         default: reg_rdata = 8'h00;
      endcase
   end

   assign irq = (sot & ien_q[0]) | (eot & ien_q[1]);

endmodule

// File: rtl/ps2_shared_engine_chk.sv
module ps2_shared_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       run,
   input logic       sot,
   input logic       eot,
   input logic       perr,
   input logic       ferr,
   input logic [2:0] ach
);

   AST_START_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sot && run) |=> sot);                                         // R4

   AST_INHIBIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!sot && !eot && !perr && !ferr));                    // R4

   AST_END_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      eot |-> sot);                                                  // R3

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      sot |-> (ach == 3'd1 || ach == 3'd2 || ach == 3'd4 || ach == 3'd5)); // R5

   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sot && run) |=> $stable(ach));                                // R6

   AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (perr || ferr) |-> eot);                                       // R8

endmodule

bind ps2_shared_engine ps2_shared_engine_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .run   (run),
   .sot   (sot),
   .eot   (eot),
   .perr  (perr),
   .ferr  (ferr),
   .ach   (ach)
);

// File: tb/tb_ps2_shared_engine.sv
module tb_ps2_shared_engine;

   localparam int HALF = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq;
   logic [3:0] dev_clk = 4'hF;
   logic [3:0] dev_dat = 4'hF;
   logic [3:0] clk_low, dat_low;
   logic [3:0] clk_line, dat_line;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   assign clk_line = dev_clk & ~clk_low;
   assign dat_line = dev_dat & ~dat_low;

   ps2_shared_engine dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .reg_wr        (reg_wr),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .irq           (irq),
      .ps2_clk_i     (clk_line),
      .ps2_dat_i     (dat_line),
      .ps2_clk_low_o (clk_low),
      .ps2_dat_low_o (dat_low)
   );

   function automatic int cpos(int p);
      case (p) 0: return 3; 1: return 4; 2: return 5; default: return 7; endcase
   endfunction
   function automatic int dpos(int p);
      case (p) 0: return 0; 1: return 1; 2: return 2; default: return 6; endcase
   endfunction
   function automatic logic [2:0] code(int p);
      case (p) 0: return 3'd1; 1: return 3'd2; 2: return 3'd4; default: return 3'd5; endcase
   endfunction
   function automatic logic oddpar(logic [7:0] b);
      return ~^b;
   endfunction
   function automatic logic [7:0] exp_stat(int p, logic pe, logic fe);
      return {1'b0, code(p), fe, pe, 1'b1, 1'b1};
   endfunction
   function automatic logic [3:0] exp_clk_low(logic [7:0] o);
      logic [3:0] r;
      for (int p = 0; p < 4; p++) r[p] = ~o[cpos(p)];
      return r;
   endfunction
   function automatic logic [3:0] exp_dat_low(logic [7:0] o);
      logic [3:0] r;
      for (int p = 0; p < 4; p++) r[p] = ~o[dpos(p)];
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic inhibit_and_open();
      wr(3'd1, 8'h47);
      settle(30);
      wr(3'd1, 8'hFF);
      settle(30);
   endtask

   task automatic dev_frame(input int p, input logic [7:0] b,
                            input bit bad_start, input bit bad_stop, input bit bad_par);
      logic [10:0] bits;
      bits[0]   = bad_start;
      bits[8:1] = b;
      bits[9]   = oddpar(b) ^ bad_par;
      bits[10]  = ~bad_stop;
      for (int k = 0; k < 11; k++) begin
         @(negedge clk); dev_dat[p] = bits[k];
         settle(HALF);
         dev_clk[p] = 1'b0;
         settle(HALF);
         dev_clk[p] = 1'b1;
      end
      settle(HALF);
      dev_dat[p] = 1'b1;
   endtask

   task automatic dev_tx(input int p, input bit ack,
                         output logic [7:0] got, output logic gpar, output logic grel);
      got = '0; gpar = 1'b0; grel = 1'b0;
      dev_dat[p] = 1'b1;
      for (int k = 1; k <= 11; k++) begin
         settle(HALF);
         if (k == 11 && ack) dev_dat[p] = 1'b0;
         settle(2);
         dev_clk[p] = 1'b0;
         settle(HALF);
         if (k <= 8)  got[k-1] = dat_line[p];
         if (k == 9)  gpar = dat_line[p];
         if (k == 10) grel = dat_line[p];
         dev_clk[p] = 1'b1;
      end
      settle(HALF);
      dev_dat[p] = 1'b1;
   endtask

   task automatic rx_case(input int p, input logic [7:0] b, input bit bs, input bit bst,
                          input bit bp, input string req);
      logic [7:0] v;
      dev_frame(p, b, bs, bst, bp);
      settle(10);
      rd(3'd2, v);
      check({req, " status"}, v, exp_stat(p, bp, bs | bst));
      rd(3'd4, v);
      check({req, " data"}, v, b);
      inhibit_and_open();
      rd(3'd2, v);
      check("R4 cleared by inhibit", v, 8'h00);
   endtask

   task automatic tx_case(input int p, input logic [7:0] b, input bit ack);
      logic [7:0] got, v;
      logic gp, gr;
      wr(3'd1, 8'h47);
      settle(30);
      wr(3'd4, b);
      wr(3'd0, 8'h03);
      wr(3'd1, (8'h47 & ~(8'h1 << dpos(p))) | (8'h1 << cpos(p)));
      settle(30);
      dev_tx(p, ack, got, gp, gr);
      settle(10);
      check("R9 tx byte", got, b);
      check("R9 tx parity", gp, oddpar(b));
      check("R9 tx release", gr, 1'b1);
      rd(3'd2, v);
      check("R9 tx status", v, exp_stat(p, 1'b0, ~ack));
      wr(3'd0, 8'h01);
      inhibit_and_open();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v, o, b0, b1;
      int p;
      void'($urandom(32'h5eed_1234));
      settle(5);
      rst_n = 1'b1;
      settle(5);

      // R1 reset state
      rd(3'd2, v);
      check("R1 status", v, 8'h00);
      check("R1 clk pulls", clk_low, 4'hF);
      check("R1 dat pulls", dat_low, 4'h0);
      check("R1 irq", irq, 1'b0);

      // R2 override layout, engine disabled
      for (int i = 0; i < 5; i++) begin
         o = (i == 0) ? 8'hA5 : 8'($urandom);
         wr(3'd1, o);
         settle(2);
         check("R2 clk pulls", clk_low, exp_clk_low(o));
         check("R2 dat pulls", dat_low, exp_dat_low(o));
      end
      wr(3'd1, 8'h47);
      settle(30);

      // R3 R5 R7 random receive frames
      wr(3'd0, 8'h01);
      inhibit_and_open();
      for (int i = 0; i < 8; i++) begin
         p = int'($urandom % 4);
         rx_case(p, 8'($urandom), 1'b0, 1'b0, 1'b0, "R3 R5 rx");
      end
      rx_case(3, 8'h00, 1'b0, 1'b0, 1'b0, "R3 zero byte");
      rx_case(0, 8'hFF, 1'b0, 1'b0, 1'b0, "R3 ones byte");

      // R7 R8 error flags
      rx_case(1, 8'h5A, 1'b0, 1'b0, 1'b1, "R7 parity");
      rx_case(2, 8'h3C, 1'b1, 1'b0, 1'b0, "R8 start high");
      rx_case(0, 8'hC3, 1'b0, 1'b1, 1'b0, "R8 stop low");

      // R6 simultaneous start on ports 1 and 3
      b0 = 8'($urandom); b1 = 8'($urandom);
      fork
         dev_frame(1, b0, 1'b0, 1'b0, 1'b0);
         dev_frame(3, b1, 1'b0, 1'b0, 1'b0);
      join
      settle(10);
      rd(3'd2, v);
      check("R6 same-cycle winner", v, exp_stat(1, 1'b0, 1'b0));
      rd(3'd4, v);
      check("R6 same-cycle data", v, b0);
      inhibit_and_open();

      // R6 simultaneous on ports 0 and 2
      b0 = 8'($urandom); b1 = 8'($urandom);
      fork
         dev_frame(2, b1, 1'b0, 1'b0, 1'b0);
         dev_frame(0, b0, 1'b0, 1'b0, 1'b0);
      join
      settle(10);
      rd(3'd2, v);
      check("R6 low port wins", v, exp_stat(0, 1'b0, 1'b0));
      rd(3'd4, v);
      check("R6 low port data", v, b0);
      inhibit_and_open();

      // R6 staggered: port 2 locks first, later port 0 edges ignored
      b0 = 8'h81; b1 = 8'h7E;
      fork
         dev_frame(2, b1, 1'b0, 1'b0, 1'b0);
         begin settle(HALF); dev_frame(0, b0, 1'b0, 1'b0, 1'b0); end
      join
      settle(10);
      rd(3'd2, v);
      check("R6 lock kept", v, exp_stat(2, 1'b0, 1'b0));
      rd(3'd4, v);
      check("R6 lock data", v, b1);
      inhibit_and_open();

      // R10 interrupts
      wr(3'd3, 8'h02);
      fork
         dev_frame(1, 8'h99, 1'b0, 1'b0, 1'b0);
         begin
            settle(6 * HALF);
            rd(3'd2, v);
            check("R10 mid-frame flags", v[1:0], 2'b01);
            check("R10 end-only mask mid-frame", irq, 1'b0);
         end
      join
      settle(10);
      check("R10 end irq", irq, 1'b1);
      wr(3'd3, 8'h01);
      settle(1);
      check("R10 start irq", irq, 1'b1);
      wr(3'd3, 8'h00);
      settle(1);
      check("R10 masked", irq, 1'b0);
      wr(3'd3, 8'h03);
      inhibit_and_open();
      check("R10 cleared by inhibit", irq, 1'b0);
      wr(3'd3, 8'h00);

      // R11 ignored while disabled or clock closed
      wr(3'd0, 8'h00);
      dev_frame(0, 8'h11, 1'b0, 1'b0, 1'b0);
      settle(10);
      rd(3'd2, v);
      check("R11 disabled", v, 8'h00);
      wr(3'd0, 8'h01);
      wr(3'd1, 8'hEF);
      settle(30);
      dev_frame(1, 8'h22, 1'b0, 1'b0, 1'b0);
      settle(10);
      rd(3'd2, v);
      check("R11 closed port", v, 8'h00);
      wr(3'd1, 8'hFF);
      settle(30);

      // R9 transmit
      tx_case(0, 8'hA7, 1'b1);
      tx_case(3, 8'h3C, 1'b1);
      tx_case(2, 8'($urandom), 1'b1);
      tx_case(1, 8'h0F, 1'b0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule